// File: doc/BRIEF.md
# Self-Timed Fuse Word Read Controller

This block sits on a simple register bus and fetches one 32-bit word from a one-time-programmable fuse array without any software pacing. Software issues a single command write that carries both start bits and a word address. The controller then walks the fuse macro through a select, address-setup and strobe sequence on its own. It captures the 32-bit word into a data register and raises a completion flag.

The completion flag drives a level-sensitive interrupt line. Software clears it by writing a one to the flag bit. The fuse array holds 32 words (128 bytes). An address past the end of the array yields a zero word, and the read still completes normally. A command that arrives while a read is still running is dropped.

Top module: `fuse_autoread_ctrl`

## Requirements
- R1: After synchronous reset, the status register (byte offset 0x18) reads 0, the data register (offset 0x20) reads 0 and `irq` is low.
- R2: A read starts only when a single write to offset 0x24 has both bit0 (enable) and bit1 (go) set. The 10-bit word address is taken from bits 25:16 of that write. A write with only one of the two bits set, or a write to any other offset, starts nothing.
- R3: After a read of word w, where w is below 32, the data register holds (w+1)*32'h9E3779B9 modulo 2^32. The data register changes at no other time.
- R4: Status bit0 becomes 1 exactly SETUP_CYC+STROBE_CYC+1 clock edges after the command edge. With the defaults this is 7 edges, which is well inside the 200-cycle (4 µs at 50 MHz) deadline.
- R5: Writing 1 to status bit0 clears the flag. Writing 0 leaves it unchanged. If a clear and a completion fall on the same edge, the flag stays set.
- R6: `irq` is high exactly while status bit0 is 1.
- R7: A word address of 32 or more completes normally and leaves 0 in the data register.
- R8: A command written while a read is in progress is ignored. The running read completes with the data of its own address.
- R9: Reads at any offset other than 0x18 and 0x20, including the write-only offset 0x24, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address while bus_rd is high, else 0 |
| irq | output | 1 | Level interrupt, high while the completion flag is set |

## Verification
The assertions assume that bus writes are single-cycle pulses sampled at the clock edge. They also assume that reset is held for at least one edge before any command, so the deadline counter and the stability checks only ever see state that was built after reset. The bench follows both rules: it drives every input at the falling edge for exactly one cycle. It sweeps all 32 in-range word addresses plus several out-of-range ones, and it times the clear-on-completion collision by counting edges from the command write.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
    localparam int DATA_W     = 32;
    localparam int WADDR_W    = 10;
    localparam int NUM_WORDS  = 32;
    localparam int IDX_W      = $clog2(NUM_WORDS);
    localparam int BUS_ADDR_W = 8;
    localparam int ADDR_LSB   = 16;

    localparam logic [BUS_ADDR_W-1:0] OFS_STATUS = 8'h18;
    localparam logic [BUS_ADDR_W-1:0] OFS_DATA   = 8'h20;
    localparam logic [BUS_ADDR_W-1:0] OFS_CTRL   = 8'h24;

    localparam logic [DATA_W-1:0] FUSE_MULT = 32'h9E3779B9;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_CAPTURE
    } seq_state_t;

    typedef struct packed {
        logic               go;
        logic [WADDR_W-1:0] waddr;
    } rd_cmd_t;

    // Contents of the modelled fuse array: word w holds (w+1)*FUSE_MULT.
    function automatic logic [DATA_W-1:0] fuse_word(input logic [IDX_W-1:0] idx);
        logic [DATA_W-1:0] n;
        n = DATA_W'(idx) + 1'b1;
        return n * FUSE_MULT;
    endfunction
endpackage

// File: rtl/fuse_macro_model.sv
module fuse_macro_model
    import fuse_rd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               strobe,
    input  logic [WADDR_W-1:0] waddr,
    output logic [DATA_W-1:0]  dout
);
    logic in_range;
    assign in_range = (waddr < WADDR_W'(NUM_WORDS));

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (sel && strobe) begin
            dout <= in_range ? fuse_word(waddr[IDX_W-1:0]) : '0;
        end
    end
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  rd_cmd_t            cmd,
    output logic               busy,
    output logic               fuse_sel,
    output logic               fuse_strobe,
    output logic [WADDR_W-1:0] fuse_addr,
    output logic               finish
);
    localparam int MAX_CYC = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            fuse_addr <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: if (cmd.go) begin
                    state     <= SQ_SETUP;
                    cnt       <= '0;
                    fuse_addr <= cmd.waddr;
                end
                SQ_SETUP: if (cnt == CNT_W'(SETUP_CYC - 1)) begin
                    state <= SQ_STROBE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SQ_STROBE: if (cnt == CNT_W'(STROBE_CYC - 1)) begin
                    state <= SQ_CAPTURE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SQ_CAPTURE: state <= SQ_IDLE;
                default:    state <= SQ_IDLE;
            endcase
        end
    end

    assign busy        = (state != SQ_IDLE);
    assign fuse_sel    = busy;
    assign fuse_strobe = (state == SQ_STROBE);
    assign finish      = (state == SQ_CAPTURE);
endmodule

// File: rtl/fuse_autoread_ctrl.sv
module fuse_autoread_ctrl
    import fuse_rd_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq
);
    rd_cmd_t             cmd;
    logic                start_req;
    logic                w1c;
    logic                seq_busy;
    logic                fuse_sel;
    logic                fuse_strobe;
    logic [WADDR_W-1:0]  fuse_addr;
    logic                finish;
    logic [DATA_W-1:0]   macro_dout;
    logic                done_q;
    logic [DATA_W-1:0]   data_q;

    // Register decode: a command needs both start bits in one write.
    assign start_req = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[0] && bus_wdata[1];
    assign w1c       = bus_wr && (bus_addr == OFS_STATUS) && bus_wdata[0];
    assign cmd.go    = start_req && !seq_busy;
    assign cmd.waddr = bus_wdata[ADDR_LSB +: WADDR_W];

    fuse_rd_seq #(
        .SETUP_CYC (SETUP_CYC),
        .STROBE_CYC(STROBE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .busy       (seq_busy),
        .fuse_sel   (fuse_sel),
        .fuse_strobe(fuse_strobe),
        .fuse_addr  (fuse_addr),
        .finish     (finish)
    );

    fuse_macro_model u_macro (
        .clk   (clk),
        .rst   (rst),
        .sel   (fuse_sel),
        .strobe(fuse_strobe),
        .waddr (fuse_addr),
        .dout  (macro_dout)
    );

    // Completion flag: a set on the same edge as a clear wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (finish) begin
                done_q <= 1'b1;
                data_q <= macro_dout;
            end else if (w1c) begin
                done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, done_q};
                OFS_DATA:   bus_rdata = data_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq = done_q;
endmodule

// File: rtl/fuse_autoread_chk.sv
module fuse_autoread_chk
    import fuse_rd_pkg::*;
#(
    parameter int LIMIT_CYC = 200
) (
    input logic               clk,
    input logic               rst,
    input logic               start_req,
    input logic               w1c,
    input logic               seq_busy,
    input logic               finish,
    input logic [WADDR_W-1:0] fuse_addr,
    input logic               done_q,
    input logic [DATA_W-1:0]  data_q,
    input logic               irq
);
    logic [15:0] age;

    always_ff @(posedge clk) begin
        if (rst || !seq_busy) age <= '0;
        else                  age <= age + 1'b1;
    end

    // R4: a running read finishes well inside the deadline.
    p_deadline_r4: assert property (@(posedge clk) disable iff (rst)
        age < 16'(LIMIT_CYC));

    // R4: completion raises the flag on the next edge.
    p_set_on_finish_r4: assert property (@(posedge clk) disable iff (rst)
        finish |=> done_q);

    // R5: a one-write clears the flag when no completion collides.
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (done_q && w1c && !finish) |=> !done_q);

    // R5: without a one-write the flag holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (done_q && !w1c) |=> done_q);

    // R3: data register only moves on completion.
    p_data_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(data_q));

    // R7: out-of-range address yields a zero word.
    p_oob_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (finish && (fuse_addr >= WADDR_W'(NUM_WORDS))) |=> (data_q == '0));

    // R8: a command during a read does not retarget it.
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && start_req) |=> $stable(fuse_addr));

    // R6: interrupt follows the flag.
    p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> irq);
endmodule

bind fuse_autoread_ctrl fuse_autoread_chk #(.LIMIT_CYC(200)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_req(start_req),
    .w1c      (w1c),
    .seq_busy (seq_busy),
    .finish   (finish),
    .fuse_addr(fuse_addr),
    .done_q   (done_q),
    .data_q   (data_q),
    .irq      (irq)
);

// File: tb/sim_fuse_autoread_ctrl.sv
module sim_fuse_autoread_ctrl;
    localparam int SETUP_CYC  = 2;
    localparam int STROBE_CYC = 4;
    localparam int LAT        = SETUP_CYC + STROBE_CYC + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fuse_autoread_ctrl #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] expect_word(input int a);
        if (a >= 32) return 32'h0;
        return 32'(a + 1) * 32'h9E3779B9;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle write; returns at the falling edge after the write edge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Read at the current falling edge (no clock advance).
    task automatic bus_read_now(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] cmd_word(input int a);
        return (32'(a) & 32'h3FF) << 16 | 32'h3;
    endfunction

    task automatic run_read(input int a);
        logic [31:0] d;
        int k;
        bus_write(8'h24, cmd_word(a));
        k = 0;
        bus_read_now(8'h18, d);
        while (d[0] !== 1'b1 && k < 250) begin
            @(negedge clk);
            k++;
            bus_read_now(8'h18, d);
        end
        check("R4 latency", 32'(k), 32'(LAT));
        check("R6 irq set", {31'b0, irq}, 32'h1);
        bus_read_now(8'h20, d);
        check(a >= 32 ? "R7 oob data" : "R3 data", d, expect_word(a));
        bus_write(8'h18, 32'h0);
        bus_read_now(8'h18, d);
        check("R5 write0 no effect", d, 32'h1);
        bus_write(8'h18, 32'h1);
        bus_read_now(8'h18, d);
        check("R5 clear", d, 32'h0);
        check("R6 irq clear", {31'b0, irq}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        int oob[5] = '{32, 33, 64, 513, 1023};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        bus_read_now(8'h18, d); check("R1 status", d, 32'h0);
        bus_read_now(8'h20, d); check("R1 data", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R3/R4/R5/R6 sweep over every in-range word
        for (int a = 0; a < 32; a++) run_read(a);
        // R7 out-of-range addresses
        foreach (oob[i]) run_read(oob[i]);

        // R2: partial or misplaced commands start nothing
        run_read(5);
        bus_write(8'h24, 32'h0009_0001);
        bus_write(8'h24, 32'h0009_0002);
        bus_write(8'h20, 32'h0009_0003);
        repeat (20) @(negedge clk);
        bus_read_now(8'h18, d); check("R2 no start status", d, 32'h0);
        bus_read_now(8'h20, d); check("R2 no start data", d, expect_word(5));

        // R8: second command while busy is dropped
        bus_write(8'h24, cmd_word(12));
        bus_write(8'h24, cmd_word(20));
        repeat (LAT + 5) @(negedge clk);
        bus_read_now(8'h20, d); check("R8 busy ignore data", d, expect_word(12));
        bus_read_now(8'h18, d); check("R8 flag", d, 32'h1);
        bus_write(8'h18, 32'h1);
        repeat (LAT + 5) @(negedge clk);
        bus_read_now(8'h18, d); check("R8 no second completion", d, 32'h0);

        // R5: clear on the completion edge keeps the flag
        bus_write(8'h24, cmd_word(7));
        repeat (LAT - 1) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        bus_read_now(8'h18, d); check("R5 set wins", d, 32'h1);
        bus_read_now(8'h20, d); check("R3 data collision", d, expect_word(7));

        // R9: unmapped and write-only offsets read zero
        bus_read_now(8'h24, d); check("R9 ctrl reads zero", d, 32'h0);
        bus_read_now(8'h00, d); check("R9 offset 0", d, 32'h0);
        bus_read_now(8'h1C, d); check("R9 offset 1C", d, 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule